// File: doc/BRIEF.md
# Sixteen-Channel Pipelined Coherent Summation Tree

This block adds sixteen sample streams that belong together but reach it at different times. Each channel delivers one signed sample per focal point, in focal-point order, marked by its own valid bit. Each channel may lead or trail the others by a bounded number of samples. The block pairs samples that share a focal-point index and returns one sum per focal point, with a valid bit, in index order.

The adders form an inverted binary tree of fifteen pair units on four levels. Each unit has a small state machine that works out which of its two inputs is ahead. It parks the early side's words in one FIFO until the matching word arrives on the other side, then adds the two and registers the result. The word grows by one bit per level, from 16 to 20 bits. The 20-bit total leaves the block as its upper 16 bits. Each level has its own FIFO depth, set from a per-level parameter array. The lower levels have the deeper FIFOs by default.

When all channels stream together the block returns one full sum per clock. Larger arrays are built by feeding the outputs of several such trees into a further tree.

Top module: `bf_sum_tree`

## Requirements
- R1: While reset is asserted, and until all sixteen samples of a focal point have arrived, `out_valid` stays low.
- R2: Each output word equals bits 19..4 of the 20-bit two's-complement sum of the sixteen signed 16-bit samples for that focal point.
- R3: Exactly one output appears per complete focal point, in focal-point order, with no extra outputs.
- R4: With all channels valid in the same cycle and back-to-back, outputs appear on consecutive cycles. The sum for samples driven before clock edge e is valid after edge e+3, a latency of four clocks.
- R5: Channels whose start times differ by up to 7 cycles, or whose streams run ahead of the slowest channel by up to 8 samples, still produce correct sums.
- R6: When one channel arrives last for a focal point, the sum appears exactly four clocks after that last sample is accepted.
- R7: Reset asserted in the middle of a stream discards every parked sample. Sums after reset contain only samples given after reset.
- R8: Truncation rounds toward minus infinity. A total of -1 gives -1, a total of +15 gives 0, and full-scale positive and negative inputs do not wrap.
- R9: The data lanes of a channel whose valid bit is low have no effect on any sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset for all units |
| in_valid | input | 16 | Per-channel sample valid, bit i for channel i |
| in_data | input | 256 | Channel i sample in bits 16*i+15..16*i, signed |
| out_valid | output | 1 | High for one cycle per completed focal-point sum |
| out_data | output | 16 | Upper 16 bits of the 20-bit coherent sum |

## Verification
Fully aligned back-to-back streams show that throughput is one sum per clock and that latency is fixed. Fixed per-channel start offsets show that the result waits for the latest channel and that outputs then run without gaps. Randomly gapped streams with a bounded lead, carrying junk on idle lanes, test whether the cross-switch keeps pairing the right indices and whether idle lanes are ignored. Extreme and small negative values tell floor truncation apart from rounding and from overflow. A single late channel, and a reset in the middle of a stream, test the completion timing and the flushing of parked words.

// File: rtl/bf_pkg.sv
package bf_pkg;
   // upper bound on tree height supported by the depth array
   localparam int unsigned MAX_LVL = 8;
   typedef int unsigned depth_arr_t [MAX_LVL];

   // pointer width for a ring of the given depth
   function automatic int unsigned ptr_w(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/bf_skew_fifo.sv
module bf_skew_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = bf_pkg::ptr_w(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bf_skew_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   assign rdata = mem[rd_ptr];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   // R5: skew within the depth never overruns the ring
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);
   // R3: a pairing only consumes a word that was parked
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/bf_pair_unit.sv
module bf_pair_unit #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         a_v,
   input  logic [W-1:0] a_d,
   input  logic         b_v,
   input  logic [W-1:0] b_d,
   output logic         o_v,
   output logic [W:0]   o_d
);
   typedef enum logic {LEAD_A = 1'b0, LEAD_B = 1'b1} lead_t;

   lead_t        lead;
   logic         push, pop, add, empty, full;
   logic         push_b;
   logic [W-1:0] push_d, head, opx, opy;

   bf_skew_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (push_d),
      .pop   (pop),
      .rdata (head),
      .empty (empty),
      .full  (full)
   );

   // cross switch: the early side is parked, the late side meets the head
   always_comb begin
      push   = 1'b0;
      push_b = 1'b0;
      pop    = 1'b0;
      add    = 1'b0;
      opx    = head;
      opy    = a_d;
      if (a_v && b_v) begin
         add = 1'b1;
         if (empty) begin
            opx = a_d;
            opy = b_d;
         end else if (lead == LEAD_A) begin
            pop  = 1'b1;
            push = 1'b1;
            opy  = b_d;
         end else begin
            pop    = 1'b1;
            push   = 1'b1;
            push_b = 1'b1;
            opy    = a_d;
         end
      end else if (a_v) begin
         if (empty || lead == LEAD_A) begin
            push = 1'b1;
         end else begin
            pop  = 1'b1;
            add  = 1'b1;
            opy  = a_d;
         end
      end else if (b_v) begin
         if (empty || lead == LEAD_B) begin
            push   = 1'b1;
            push_b = 1'b1;
         end else begin
            pop  = 1'b1;
            add  = 1'b1;
            opy  = b_d;
         end
      end
      push_d = push_b ? b_d : a_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lead <= LEAD_A;
         o_v  <= 1'b0;
         o_d  <= '0;
      end else begin
         if (push && empty) lead <= push_b ? LEAD_B : LEAD_A;
         o_v <= add;
         if (add) o_d <= {opx[W-1], opx} + {opy[W-1], opy};
      end
   end

   // R9: a result is only produced in a cycle where some input was valid
   a_r9_out_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      o_v |-> $past(a_v || b_v));
endmodule

// File: rtl/bf_sum_tree.sv
module bf_sum_tree #(
   parameter int unsigned        CH        = 16,
   parameter int unsigned        IN_W      = 16,
   parameter int unsigned        OUT_W     = 16,
   parameter bf_pkg::depth_arr_t LVL_DEPTH = '{16, 12, 10, 9, 8, 8, 8, 8}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CH-1:0]        in_valid,
   input  logic [CH*IN_W-1:0]   in_data,
   output logic                 out_valid,
   output logic [OUT_W-1:0]     out_data
);
   localparam int unsigned LEVELS = $clog2(CH);
   localparam int unsigned FULL_W = IN_W + LEVELS;
   localparam int unsigned SC_W   = $clog2(LEVELS + 1);

   if (CH < 2 || (1 << LEVELS) != CH) begin : g_bad_ch
      $error("bf_sum_tree: CH must be a power of two, at least 2");
   end
   if (LEVELS > bf_pkg::MAX_LVL) begin : g_bad_lvl
      $error("bf_sum_tree: tree deeper than the depth array");
   end
   if (OUT_W > FULL_W || OUT_W == 0) begin : g_bad_out
      $error("bf_sum_tree: OUT_W must lie in 1..IN_W+log2(CH)");
   end

   // heap-ordered nodes: root 1, node n fed by 2n and 2n+1, leaves CH..2CH-1
   logic              node_v [1:2*CH-1];
   logic [FULL_W-1:0] node_d [1:2*CH-1];

   for (genvar i = 0; i < CH; i++) begin : g_leaf
      assign node_v[CH+i] = in_valid[i];
      assign node_d[CH+i] = FULL_W'($signed(in_data[i*IN_W +: IN_W]));
   end

   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      localparam int unsigned UW = IN_W + k;
      localparam int unsigned NU = CH >> (k + 1);
      for (genvar u = 0; u < NU; u++) begin : g_unit
         localparam int unsigned N = NU + u;
         logic        ov;
         logic [UW:0] od;
         bf_pair_unit #(.W(UW), .DEPTH(LVL_DEPTH[k])) i_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .a_v   (node_v[2*N]),
            .a_d   (node_d[2*N][UW-1:0]),
            .b_v   (node_v[2*N+1]),
            .b_d   (node_d[2*N+1][UW-1:0]),
            .o_v   (ov),
            .o_d   (od)
         );
         assign node_v[N] = ov;
         assign node_d[N] = FULL_W'($signed(od));
      end
   end

   assign out_valid = node_v[1];
   assign out_data  = node_d[1][FULL_W-1 -: OUT_W];

   // cycles since reset release, saturating at the tree height
   logic [SC_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                          since_rst <= '0;
      else if (since_rst != SC_W'(LEVELS)) since_rst <= since_rst + 1'b1;
   end

   // R1: no sum can leave before the pipeline has filled once
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < SC_W'(LEVELS)) |-> !out_valid);
   // R2: a delivered sum is always a defined value
   a_r2_known_result: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_data));
endmodule

// File: tb/test_bf_sum_tree.sv
module test_bf_sum_tree;
   localparam int CLK_PERIOD = 10;
   localparam int CH    = 16;
   localparam int IN_W  = 16;
   localparam int OUT_W = 16;
   localparam int SHIFT = 4;
   localparam int MAXN  = 64;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [CH-1:0]      in_valid = '0;
   logic [CH*IN_W-1:0] in_data = '0;
   logic               out_valid;
   logic [OUT_W-1:0]   out_data;

   int vectors = 0;
   int miscompares = 0;
   logic signed [IN_W-1:0] smp [CH][MAXN];

   always #(CLK_PERIOD/2) clk = ~clk;

   bf_sum_tree i_bf_sum_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   function automatic logic [OUT_W-1:0] expd(input int idx);
      int s = 0;
      for (int c = 0; c < CH; c++) s += int'(smp[c][idx]);
      return OUT_W'(s >>> SHIFT);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic fill_random(input int n);
      for (int j = 0; j < n; j++)
         for (int c = 0; c < CH; c++) smp[c][j] = IN_W'($urandom);
   endtask

   // mode 0: aligned, 1: fixed start offsets, 2: random gaps with bounded lead
   task automatic run_stream(input int n, input int mode, input int off[CH],
                             input string req, input bit timed);
      int sent[CH];
      int got = 0;
      int maxoff = 0;
      int done_cyc = -1;
      for (int c = 0; c < CH; c++) begin
         sent[c] = 0;
         if (mode == 1 && off[c] > maxoff) maxoff = off[c];
      end
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int minsent;
         bit alldone;
         @(negedge clk);
         if (out_valid) begin
            if (got < n) begin
               chk(out_data == expd(got), {req, " sum"},
                   int'($signed(out_data)), int'($signed(expd(got))));
               if (timed)
                  chk(cyc == maxoff + 4 + got, {req, " timing"}, cyc, maxoff + 4 + got);
            end else begin
               chk(1'b0, "R3 extra output", got + 1, n);
            end
            got++;
         end
         minsent = n;
         for (int c = 0; c < CH; c++) if (sent[c] < minsent) minsent = sent[c];
         alldone = 1'b1;
         for (int c = 0; c < CH; c++) begin
            bit go = 1'b0;
            if (sent[c] < n) begin
               case (mode)
                  0: go = 1'b1;
                  1: go = (cyc >= off[c]);
                  default: go = (($urandom % 3) != 0) && (sent[c] - minsent < 8);
               endcase
            end
            in_valid[c] = go;
            in_data[c*IN_W +: IN_W] = go ? smp[c][sent[c]] : IN_W'($urandom);
            if (go) sent[c]++;
            if (sent[c] < n) alldone = 1'b0;
         end
         if (alldone && done_cyc < 0) done_cyc = cyc;
         if (done_cyc >= 0 && cyc >= done_cyc + 10) break;
      end
      @(negedge clk);
      in_valid = '0;
      chk(got == n, {req, " R3 output count"}, got, n);
   endtask

   task automatic t_reset;
      chk(out_valid == 1'b0, "R1 during reset", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
      end
   endtask

   task automatic t_aligned;
      int off[CH];
      for (int c = 0; c < CH; c++) off[c] = 0;
      fill_random(24);
      run_stream(24, 0, off, "R4 aligned", 1'b1);
   endtask

   task automatic t_stagger;
      int off[CH];
      for (int c = 0; c < CH; c++) off[c] = (c * 5) % 8;
      fill_random(20);
      run_stream(20, 1, off, "R5 staggered", 1'b1);
   endtask

   task automatic t_bursty;
      int off[CH];
      for (int c = 0; c < CH; c++) off[c] = 0;
      fill_random(MAXN);
      run_stream(MAXN, 2, off, "R5 R9 bursty", 1'b0);
   endtask

   task automatic t_late_channel;
      int off[CH];
      for (int c = 0; c < CH; c++) off[c] = (c == 9) ? 6 : 0;
      fill_random(1);
      run_stream(1, 1, off, "R6 R1 last arrival", 1'b1);
   endtask

   task automatic t_extremes;
      int off[CH];
      for (int c = 0; c < CH; c++) begin
         off[c]    = 0;
         smp[c][0] = 16'sh7FFF;
         smp[c][1] = -16'sh8000;
         smp[c][2] = (c == 0) ? -16'sd1 : 16'sd0;
         smp[c][3] = -16'sd1;
         smp[c][4] = (c == 3) ? 16'sd15 : 16'sd0;
         smp[c][5] = c[0] ? -16'sh8000 : 16'sh7FFF;
      end
      chk(expd(2) == 16'hFFFF, "R8 floor of -1", int'($signed(expd(2))), -1);
      chk(expd(4) == 16'h0000, "R8 floor of +15", int'($signed(expd(4))), 0);
      run_stream(6, 0, off, "R8 R2 extremes", 1'b1);
   endtask

   task automatic t_midreset;
      int off[CH];
      @(negedge clk);
      for (int c = 0; c < CH; c++) begin
         off[c] = 0;
         in_valid[c] = (c < 8);
         in_data[c*IN_W +: IN_W] = 16'sd1000;
      end
      @(negedge clk);
      in_valid = '0;
      @(negedge clk);
      in_valid = 16'h00F0;
      @(negedge clk);
      in_valid = '0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R7 quiet after flush", int'(out_valid), 0);
      end
      fill_random(10);
      run_stream(10, 0, off, "R7 after flush", 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R3 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_aligned();
      t_stagger();
      t_bursty();
      t_late_channel();
      t_extremes();
      t_midreset();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule